// File: doc/BRIEF.md
# Dual-Edge ADC Sample Capture Packer

This block takes a converter's sample bus, 14 data bits plus an overrange bit, on both edges of the capture clock. The converter delivers one sample per clock edge, which is 400 MSPS on a 200 MHz clock. The sample taken on a rising edge is paired with the one taken on the falling edge that follows it. Together they leave as one 32-bit word with a one-cycle valid strobe, all in the capture clock domain.

A capture begins when the enable input rises. Each emitted word adds two to an internal sample counter. The run finishes on the word that brings the counter to the programmed length, or earlier when the forced-stop input is sampled high. A one-cycle done pulse ends every completed run, and a separate flag beside it marks a forced stop. If enable is dropped in the middle of a run, the incomplete pair is discarded and no done pulse is given. Downstream logic takes over the clock-domain crossing and the storage.

Top module: `adc_pair_capture`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, word_valid_o, done_o and done_forced_o are 0 and word_o is all zeros.
- R2: A word emitted at rising edge k+1 holds the sample taken at rising edge k in bits [15:0] and the sample taken at the falling edge between k and k+1 in bits [31:16].
- R3: Each 16-bit half is laid out as {overrange, 1'b0, data[13:0]}, so bit 15 (and 31) carries the overrange bit and bit 14 (and 30) is always 0.
- R4: A capture starts at a rising clock edge where cap_en_i is high after having been low at the edge before. The sample taken at that edge opens the first pair, and that pair is emitted at the next edge. No word is emitted outside a capture.
- R5: Every emitted word adds 2 to the sample counter. The word that brings the counter to at least sample_count_i (which must be even) carries done_o = 1 with done_forced_o = 0, and no further word follows until a new capture starts.
- R6: When force_stop_i is high at an edge during a capture, no word is emitted at that edge and the pending pair is dropped. done_o and done_forced_o are both 1 for that one cycle, and the capture ends.
- R7: When cap_en_i is low at an edge during a capture, the incomplete pair is discarded, no word is emitted, done_o stays 0 and the capture ends.
- R8: A new capture clears the sample counter, so its length is measured from its own first word.
- R9: word_valid_o is only ever 1 in the cycle after an edge at which cap_en_i was high.
- R10: done_o never stays high for two consecutive cycles, and done_forced_o is only high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source-synchronous capture clock, both edges used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Capture enable; its rising edge starts a run |
| force_stop_i | input | 1 | Ends a running capture immediately |
| sample_count_i | input | CNT_W | Samples to capture, even |
| adc_data_i | input | 14 | Converter sample bits |
| adc_ovr_i | input | 1 | Converter overrange bit |
| word_o | output | 32 | Packed sample pair |
| word_valid_o | output | 1 | word_o carries a new pair this cycle |
| done_o | output | 1 | One-cycle end-of-capture pulse |
| done_forced_o | output | 1 | Set with done_o when a forced stop ended the run |

## Verification
The assertions check properties on every cycle: valid only follows an enabled edge, the spare bits of both halves stay zero, the done pulse lasts one cycle, a forced flag never appears without done or alongside a word, and every unforced done comes with a word. Several behaviours can only be shown by the bench's scenarios against a scoreboard of expected pairs. These are the edge-to-half assignment of each sample, the exact length of a run against the programmed count, which pair a forced stop or an enable drop throws away, and that a restart measures from zero.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int ADC_DATA_W = 14;
  localparam int ADC_SLOT_W = 16;
  localparam int ADC_LANES  = 2;
  localparam int ADC_WORD_W = ADC_SLOT_W * ADC_LANES;
  localparam int ADC_PAD_W  = ADC_SLOT_W - ADC_DATA_W - 1;

  typedef struct packed {
    logic                  ovr;
    logic [ADC_DATA_W-1:0] data;
  } adc_sample_t;

  typedef enum logic {CAP_IDLE, CAP_RUN} cap_state_e;

  function automatic logic [ADC_SLOT_W-1:0] slot_pack(adc_sample_t s);
    return {s.ovr, {ADC_PAD_W{1'b0}}, s.data};
  endfunction
endpackage

// File: rtl/adc_ddr_in.sv
module adc_ddr_in
  import adc_cap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  adc_sample_t smp_i,
  output adc_sample_t rise_o,
  output adc_sample_t fall_o
);
  adc_sample_t rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= smp_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= smp_i;
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt
  import adc_cap_pkg::*;
(
  input  adc_sample_t             early_i,
  input  adc_sample_t             late_i,
  output logic [ADC_WORD_W-1:0]   word_o
);
  adc_sample_t lane [ADC_LANES];

  // lane 0 = earlier (rising-edge) sample
  assign lane[0] = early_i;
  assign lane[1] = late_i;

  for (genvar g = 0; g < ADC_LANES; g++) begin : g_lane
    assign word_o[g*ADC_SLOT_W +: ADC_SLOT_W] = slot_pack(lane[g]);
  end
endmodule

// File: rtl/adc_pair_ctrl.sv
module adc_pair_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic             force_stop_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             emit_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             forced_o
);
  cap_state_e       state_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             start;
  logic             last;

  assign start   = cap_en_i & ~en_q;
  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(2);
  assign last    = cnt_nxt >= {1'b0, target_i};
  assign emit_o  = (state_q == CAP_RUN) & cap_en_i & ~force_stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAP_IDLE;
      en_q     <= 1'b0;
      cnt_q    <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
      forced_o <= 1'b0;
    end else begin
      en_q     <= cap_en_i;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
      forced_o <= 1'b0;
      if (start) begin
        state_q <= CAP_RUN;
        cnt_q   <= '0;
      end else if (state_q == CAP_RUN) begin
        if (!cap_en_i) begin
          state_q <= CAP_IDLE;            // partial pair dropped
        end else if (force_stop_i) begin
          state_q  <= CAP_IDLE;
          done_o   <= 1'b1;
          forced_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          cnt_q   <= cnt_nxt[CNT_W-1:0];
          if (last) begin
            state_q <= CAP_IDLE;
            done_o  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_cap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_en_i,
  input  logic                  force_stop_i,
  input  logic [CNT_W-1:0]      sample_count_i,
  input  logic [ADC_DATA_W-1:0] adc_data_i,
  input  logic                  adc_ovr_i,
  output logic [ADC_WORD_W-1:0] word_o,
  output logic                  word_valid_o,
  output logic                  done_o,
  output logic                  done_forced_o
);
  adc_sample_t           smp_in, rise_s, fall_s;
  logic [ADC_WORD_W-1:0] packed_w;
  logic                  emit;

  assign smp_in = '{ovr: adc_ovr_i, data: adc_data_i};

  adc_ddr_in i_ddr_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_in),
    .rise_o(rise_s),
    .fall_o(fall_s)
  );

  adc_word_fmt i_fmt (
    .early_i(rise_s),
    .late_i (fall_s),
    .word_o (packed_w)
  );

  adc_pair_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_en_i    (cap_en_i),
    .force_stop_i(force_stop_i),
    .target_i    (sample_count_i),
    .emit_o      (emit),
    .valid_o     (word_valid_o),
    .done_o      (done_o),
    .forced_o    (done_forced_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (emit) word_o <= packed_w;
  end
endmodule

// File: rtl/adc_pair_capture_chk.sv
module adc_pair_capture_chk
  import adc_cap_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cap_en_i,
  input logic [ADC_WORD_W-1:0] word_o,
  input logic                  word_valid_o,
  input logic                  done_o,
  input logic                  done_forced_o
);
  AST_VALID_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(cap_en_i)); // R9

  AST_PAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_o[ADC_DATA_W] == 1'b0 && word_o[ADC_SLOT_W+ADC_DATA_W] == 1'b0)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_FORCED_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_forced_o |-> done_o); // R10

  AST_FORCED_NO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_forced_o |-> !word_valid_o); // R6

  AST_COUNT_DONE_HAS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_forced_o) |-> word_valid_o); // R5
endmodule

bind adc_pair_capture adc_pair_capture_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_en_i     (cap_en_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .done_o       (done_o),
  .done_forced_o(done_forced_o)
);

// File: tb/test_adc_pair_capture.sv
module test_adc_pair_capture;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cap_en_i = 1'b0;
  logic        force_stop_i = 1'b0;
  logic [CNT_W-1:0] sample_count_i = '0;
  logic [13:0] adc_data_i = '0;
  logic        adc_ovr_i = 1'b0;
  logic [31:0] word_o;
  logic        word_valid_o, done_o, done_forced_o;

  int n_chk = 0;
  int n_fail = 0;
  int smp_idx = 0;
  logic [32:0] exp_q[$];   // {last, word}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_pair_capture #(.CNT_W(CNT_W)) i_adc_pair_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_en_i(cap_en_i),
    .force_stop_i(force_stop_i), .sample_count_i(sample_count_i),
    .adc_data_i(adc_data_i), .adc_ovr_i(adc_ovr_i),
    .word_o(word_o), .word_valid_o(word_valid_o),
    .done_o(done_o), .done_forced_o(done_forced_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] gen_smp(int i);
    return {1'(i % 3 == 0), 14'((i * 911 + 37) & 14'h3fff)};
  endfunction

  function automatic logic [15:0] slot(logic [14:0] s);
    return {s[14], 1'b0, s[13:0]};   // R3 layout
  endfunction

  // Rising sample set before the next posedge, falling sample before the following negedge.
  task automatic drive_pair(logic en, logic stop, logic push, logic last);
    logic [14:0] r, f;
    r = gen_smp(smp_idx);
    f = gen_smp(smp_idx + 1);
    smp_idx += 2;
    @(negedge clk_i); #(CLK_PERIOD/5);
    {adc_ovr_i, adc_data_i} = r;
    cap_en_i = en;
    force_stop_i = stop;
    @(posedge clk_i); #(CLK_PERIOD/5);
    {adc_ovr_i, adc_data_i} = f;
    if (push) exp_q.push_back({last, slot(f), slot(r)});
  endtask

  // Scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (word_valid_o) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected word", {32'h0, word_o}, 64'hDEAD);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk("R2/R3 word", {32'h0, word_o}, {32'h0, e[31:0]});
          chk("R5 done on last word", {63'h0, done_o}, {63'h0, e[32]});
          chk("R10 forced flag on word", {63'h0, done_forced_o}, 64'h0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/5);
    chk("R1 reset word", {32'h0, word_o}, 64'h0);
    chk("R1 reset flags", {61'h0, word_valid_o, done_o, done_forced_o}, 64'h0);
    @(negedge clk_i); #(CLK_PERIOD/5);
    rst_ni = 1'b1;
    @(posedge clk_i); #(CLK_PERIOD/5);
    chk("R1 first cycle after reset", {61'h0, word_valid_o, done_o, done_forced_o}, 64'h0);

    // R4: idle, no words while enable low
    for (int i = 0; i < 3; i++) drive_pair(1'b0, 1'b0, 1'b0, 1'b0);

    // R5/R2: run of 8 samples, then enable stays high with no more words
    sample_count_i = 24'd8;
    for (int i = 0; i < 4; i++) drive_pair(1'b1, 1'b0, 1'b1, i == 3);
    for (int i = 0; i < 3; i++) drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 run stopped after count", {32'h0, 32'(exp_q.size())}, 64'h0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);

    // R6: forced stop drops the pending pair
    sample_count_i = 24'd100;
    drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
    drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
    drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    drive_pair(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 forced done", {62'h0, done_o, done_forced_o}, 64'h3);
    chk("R6 no word on forced stop", {63'h0, word_valid_o}, 64'h0);
    drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 done is one cycle", {62'h0, done_o, done_forced_o}, 64'h0);
    chk("R6 capture ended", {32'h0, 32'(exp_q.size())}, 64'h0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);

    // R7: enable dropped mid-run
    drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
    drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
    drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 no word and no done", {62'h0, word_valid_o, done_o}, 64'h0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 still quiet", {62'h0, word_valid_o, done_o}, 64'h0);

    // R8: restart with short target counts from zero
    sample_count_i = 24'd4;
    drive_pair(1'b1, 1'b0, 1'b1, 1'b0);
    drive_pair(1'b1, 1'b0, 1'b1, 1'b1);
    drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 restart length", {32'h0, 32'(exp_q.size())}, 64'h0);

    // R2/R3/R5: longer run of 32 samples
    sample_count_i = 24'd32;
    for (int i = 0; i < 16; i++) drive_pair(1'b1, 1'b0, 1'b1, i == 15);
    drive_pair(1'b1, 1'b0, 1'b0, 1'b0);
    drive_pair(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 long run drained", {32'h0, 32'(exp_q.size())}, 64'h0);

    finish_run();
  end
endmodule